// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block takes a single reference PWM level, normally produced by a timer compare channel, and drives two pins: a main output that follows the reference and a complementary output that follows its inverse. When both outputs are enabled, the block holds back each output's turn-on by a programmable number of clock cycles. Both pins are then never active together, and the external power switches have time to turn off before their partners turn on. Turn-off is never delayed.

The delay is linear. A dead-time value of N holds each rising edge back by N clock cycles, and N = 0 adds nothing. A reference phase that lasts N samples or fewer is absorbed completely, so the output for that phase stays inactive. Each output has its own enable and polarity control. A master output-enable forces both pins to their inactive level at once.

Top module: `dtg_complementary`

## Requirements
- R1: While `rst` is high at a clock edge, the delay state is cleared. After that edge each pin sits at its inactive level, which equals its polarity bit (`main_pol` for `main_out`, `comp_pol` for `comp_out`).
- R2: With both enables set and dead time D, the main phase becomes active D cycles later than it would with D = 0. With D = 0 it is active in the cycle after the first clock edge that samples `ref_in` high.
- R3: With both enables set, the complementary phase becomes active D cycles after the first clock edge that samples `ref_in` low, counted the same way as R2.
- R4: A phase becomes inactive in the cycle after the clock edge that samples its level going away (`ref_in` low for main, `ref_in` high for complementary), with no delay.
- R5: A run of L consecutive samples at a phase's level gives max(L - D, 0) active cycles for that phase. A run with L <= D gives no pulse.
- R6: The active phases of the main and complementary outputs never overlap, for any dead-time value, enable or polarity setting.
- R7: Dead time applies only when `main_en` and `comp_en` are both 1. With only one enable set, that output follows its level with zero delay. An output whose enable is 0 stays at its inactive level.
- R8: Each pin shows its active phase XOR its polarity bit. Polarity 0 means active-high and polarity 1 means active-low.
- R9: While `out_en` is 0, both pins sit at their inactive levels in that same cycle, with no clock edge needed.
- R10: The dead-time value is captured at the clock edge that samples a level change. Changes to `dt_val` during a pending count do not affect that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference PWM level |
| dt_val | input | 8 | Dead time in clock cycles |
| main_en | input | 1 | Main output enable |
| comp_en | input | 1 | Complementary output enable |
| main_pol | input | 1 | Main polarity (1 = active-low) |
| comp_pol | input | 1 | Complementary polarity (1 = active-low) |
| out_en | input | 1 | Master output enable |
| main_out | output | 1 | Main pin |
| comp_out | output | 1 | Complementary pin |

## Verification
Two events can land on the same clock edge: the end of one phase's dead-time count, and a reference edge that ends that phase and starts the other's count. The bench provokes this with runs exactly D and D+1 samples long, and with random run lengths scattered around the dead time. At such an edge the expected result is that the expiring phase never turns on and the other phase begins a fresh count. A per-cycle reference model in the bench judges this, together with a pin-level check that the two active phases never coincide.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

  localparam int unsigned DTG_CH = 2;
  localparam int unsigned CH_MAIN = 0;
  localparam int unsigned CH_COMP = 1;

  // Effective delay: dead time only applies when both outputs are enabled.
  function automatic logic [7:0] dtg_eff_delay(input logic [7:0] dt,
                                               input logic en_a,
                                               input logic en_b);
    return (en_a && en_b) ? dt : 8'd0;
  endfunction

  // Pin level from shaped phase, enable, polarity and master enable.
  function automatic logic dtg_pin_level(input logic act,
                                         input logic en,
                                         input logic pol,
                                         input logic oe);
    logic drive;
    drive = oe & en & act;
    return drive ^ pol;
  endfunction

endpackage

// File: rtl/dtg_edge_delay.sv
`timescale 1ns/1ps
module dtg_edge_delay #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] dt_i,
  output logic             act_o,
  output logic             rise_o,
  output logic             busy_o
);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             rise;

  assign rise   = lvl_i & ~lvl_q;
  assign rise_o = rise;
  assign busy_o = (cnt_q != '0);
  assign act_o  = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (!lvl_i) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else if (rise) begin
        cnt_q <= dt_i;
        act_q <= (dt_i == '0);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        act_q <= (cnt_q == CNT_W'(1));
      end else begin
        act_q <= 1'b1;
      end
    end
  end

  // R4: level gone at the previous edge means phase inactive now
  a_r4_fall_immediate: assert property (@(posedge clk) disable iff (rst)
    !$past(lvl_i) |-> !act_q);

  // R5: a running count keeps the phase inactive
  a_r5_count_blocks: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !act_q);

  // R10: a pending count steps down by one while the level holds
  a_r10_count_steps: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q != '0) && lvl_i) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/dtg_pin_stage.sv
`timescale 1ns/1ps
module dtg_pin_stage
  import dtg_pkg::*;
(
  input  logic act_i,
  input  logic en_i,
  input  logic pol_i,
  input  logic oe_i,
  output logic pin_o
);

  always_comb pin_o = dtg_pin_level(act_i, en_i, pol_i, oe_i);

  // R9 / R7: with the pin gated off it shows its polarity bit
  always_comb begin
    if (!(oe_i && en_i)) begin
      a_r9_idle_level: assert (pin_o == pol_i);
    end
  end

endmodule

// File: rtl/dtg_complementary.sv
`timescale 1ns/1ps
module dtg_complementary
  import dtg_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_in,
  input  logic [DT_W-1:0] dt_val,
  input  logic            main_en,
  input  logic            comp_en,
  input  logic            main_pol,
  input  logic            comp_pol,
  input  logic            out_en,
  output logic            main_out,
  output logic            comp_out
);

  localparam int unsigned NCH = DTG_CH;

  logic [DT_W-1:0] eff_dt;
  logic            dt_on;
  logic [NCH-1:0]  lvl;
  logic [NCH-1:0]  act;
  logic [NCH-1:0]  rise_evt;
  logic [NCH-1:0]  busy;
  logic [NCH-1:0]  en;
  logic [NCH-1:0]  pol;
  logic [NCH-1:0]  pin;

  assign dt_on  = main_en & comp_en;
  assign eff_dt = DT_W'(dtg_eff_delay(8'(dt_val), main_en, comp_en));

  assign lvl[CH_MAIN] = ref_in;
  assign lvl[CH_COMP] = ~ref_in;
  assign en[CH_MAIN]  = main_en;
  assign en[CH_COMP]  = comp_en;
  assign pol[CH_MAIN] = main_pol;
  assign pol[CH_COMP] = comp_pol;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dtg_edge_delay #(.CNT_W(DT_W)) u_delay (
      .clk   (clk),
      .rst   (rst),
      .lvl_i (lvl[g]),
      .dt_i  (eff_dt),
      .act_o (act[g]),
      .rise_o(rise_evt[g]),
      .busy_o(busy[g])
    );
    dtg_pin_stage u_pin (
      .act_i(act[g]),
      .en_i (en[g]),
      .pol_i(pol[g]),
      .oe_i (out_en),
      .pin_o(pin[g])
    );
  end

  assign main_out = pin[CH_MAIN];
  assign comp_out = pin[CH_COMP];

  // R6: the two shaped phases are never active together
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(act[CH_MAIN] && act[CH_COMP]));

  // R3: only one phase can start a count at a time
  a_r3_one_edge: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rise_evt));

  // R7: with dead time off no phase is ever waiting
  a_r7_no_wait_single: assert property (@(posedge clk) disable iff (rst)
    (!$past(dt_on) && !dt_on) |-> !(|busy));

  // R1: after a reset edge both phases are inactive
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (act == '0));

endmodule

// File: tb/tb_dtg_complementary.sv
`timescale 1ns/1ps
module tb_dtg_complementary;

  logic       clk = 1'b0;
  logic       rst;
  logic       ref_in;
  logic [7:0] dt_val;
  logic       main_en, comp_en, main_pol, comp_pol, out_en;
  logic       main_out, comp_out;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R2";

  int run_len [2];
  int cap_dt  [2];
  bit exp_act [2];

  always #10 clk = ~clk;

  dtg_complementary dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .dt_val(dt_val),
    .main_en(main_en), .comp_en(comp_en), .main_pol(main_pol),
    .comp_pol(comp_pol), .out_en(out_en),
    .main_out(main_out), .comp_out(comp_out)
  );

  function automatic bit pin_exp(bit act, bit en, bit pol, bit oe);
    if (!oe || !en) return pol;
    return act ? !pol : pol;
  endfunction

  task automatic check(string req, logic got, logic exp, string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_update();
    int eff;
    bit lv;
    eff = (main_en && comp_en) ? int'(dt_val) : 0;
    for (int c = 0; c < 2; c++) begin
      lv = (c == 0) ? ref_in : !ref_in;
      if (rst || !lv) begin
        run_len[c] = 0;
        exp_act[c] = 1'b0;
      end else begin
        if (run_len[c] == 0) cap_dt[c] = eff;
        exp_act[c] = (run_len[c] >= cap_dt[c]);
        if (run_len[c] < 100000) run_len[c]++;
      end
    end
  endtask

  task automatic check_pins();
    check(cur_req, main_out, pin_exp(exp_act[0], main_en, main_pol, out_en), "main_out");
    check(cur_req, comp_out, pin_exp(exp_act[1], comp_en, comp_pol, out_en), "comp_out");
    check("R6", ((main_out != main_pol) && (comp_out != comp_pol)), 1'b0, "overlap");
  endtask

  task automatic step(logic r);
    ref_in = r;
    @(posedge clk);
    @(negedge clk);
    model_update();
    check_pins();
  endtask

  task automatic hold(logic r, int n);
    for (int i = 0; i < n; i++) step(r);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; ref_in = 1'b1; dt_val = 8'd3;
    main_en = 1; comp_en = 1; main_pol = 0; comp_pol = 1; out_en = 1;
    for (int c = 0; c < 2; c++) begin run_len[c] = 0; cap_dt[c] = 0; exp_act[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    model_update();
    check_pins();
    check("R1", main_out, 1'b0, "main reset level");
    check("R1", comp_out, 1'b1, "comp reset level");
    rst = 1'b0;
    comp_pol = 0;

    // R2 / R3 / R4: exact delays, dt = 3
    cur_req = "R2"; hold(1'b0, 6); hold(1'b1, 10);
    cur_req = "R3"; hold(1'b0, 10);
    cur_req = "R4"; hold(1'b1, 5); hold(1'b0, 5);
    dt_val = 0; cur_req = "R2"; hold(1'b1, 4); hold(1'b0, 4); hold(1'b1, 1); hold(1'b0, 1);

    // R5: pulses of length D and D+1 with D = 4
    dt_val = 4; cur_req = "R5";
    for (int k = 0; k < 4; k++) begin hold(1'b1, 4); hold(1'b0, 8); hold(1'b1, 5); hold(1'b0, 5); end
    hold(1'b1, 2); hold(1'b0, 4);

    // R10: change dt during a pending count
    cur_req = "R10"; dt_val = 6; step(1'b1); step(1'b1); dt_val = 1; hold(1'b1, 8);
    dt_val = 7; step(1'b0); dt_val = 0; hold(1'b0, 9);

    // R7: single enable, zero delay; disabled pin inactive
    cur_req = "R7"; dt_val = 5; comp_en = 0; hold(1'b1, 3); hold(1'b0, 3); hold(1'b1, 1); hold(1'b0, 2);
    main_en = 0; comp_en = 1; hold(1'b1, 3); hold(1'b0, 3); hold(1'b1, 2);
    main_en = 1;

    // R8: polarity combinations
    cur_req = "R8"; dt_val = 2;
    for (int p = 0; p < 4; p++) begin
      main_pol = p[0]; comp_pol = p[1];
      hold(1'b1, 5); hold(1'b0, 5);
    end
    main_pol = 0; comp_pol = 0;

    // R9: master enable drops mid-phase
    cur_req = "R9"; dt_val = 1; hold(1'b1, 4); out_en = 0; hold(1'b1, 2); hold(1'b0, 3);
    out_en = 1; hold(1'b0, 3); main_pol = 1; comp_pol = 1; out_en = 0; hold(1'b1, 3);
    out_en = 1; main_pol = 0; comp_pol = 0;

    // R2: full-scale dead time
    cur_req = "R2"; dt_val = 8'd255; hold(1'b1, 300); hold(1'b0, 256); hold(1'b1, 255); hold(1'b0, 3);

    // Random runs around the dead time, occasional config changes
    begin
      int unsigned seed_v;
      int len;
      bit lvl;
      seed_v = $urandom(32'h5EED_0042);
      lvl = 1'b0;
      cur_req = "R5";
      for (int it = 0; it < 2500; it++) begin
        if (($urandom % 8) == 0) dt_val = 8'($urandom % 12);
        if (($urandom % 40) == 0) begin
          main_en = ($urandom % 4) != 0; comp_en = ($urandom % 4) != 0;
          main_pol = $urandom % 2; comp_pol = $urandom % 2;
          out_en = ($urandom % 6) != 0;
        end
        len = 1 + int'($urandom % (int'(dt_val) + 4));
        lvl = !lvl;
        hold(lvl, len);
      end
      cur_req = "R1";
      rst = 1'b1; step(1'b1); rst = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule